// File: doc/BRIEF.md
# VME Single-Cycle Read Master

This block runs exactly one read cycle on a VME backplane for each accepted request. A request gives a 32-bit byte address, a 6-bit address modifier and an access size. The block puts the address and modifier on the bus and waits a programmable setup time before it asserts the address strobe. It makes sure the slave from the previous cycle has stopped driving its acknowledge enable and bus error. It then asserts the data strobes that match the access size and the low address bits, and it waits for the acknowledge.

When the cycle ends, the block releases the strobes and pulses a one-cycle completion flag. With that flag it returns the read data, right-aligned and zero-extended, and an error bit. The error bit is set in two cases: the slave did not answer within the timeout, or the request was misaligned. A misaligned request produces no bus activity at all. All bus inputs pass through two-flop synchronizers before the control logic uses them. Requests that arrive while a cycle is running are dropped.

Top module: `vme_rd_master`

## Requirements
- R1: While a cycle runs, the address lines carry request address bits 31:1 and the modifier lines carry the request modifier. IACK and WRITE stay high at all times.
- R2: AS falls exactly SETUP_CYC clock cycles after the clock edge that accepts the request. Address and modifier lines do not change on that edge.
- R3: After AS falls, the data strobes stay at 11 while the synchronized DTACK drive enable or the synchronized BERR is high.
- R4: Size code 00 (byte) keeps LWORD high. It drives DS = 01 for an even address and DS = 10 for an odd address. It returns data bits 15:8 (even) or 7:0 (odd) in result bits 7:0, with the upper bits zero.
- R5: Size code 01 (16-bit) keeps LWORD high, drives DS = 00 and returns data bits 15:0, zero-extended.
- R6: Size code 10 (32-bit) drives LWORD low, drives DS = 00 and returns data bits 31:0.
- R7: The data phase ends with the error flag low once the DTACK drive enable is high and DTACK is low, after the two-flop synchronization. The data is sampled through the same synchronizer.
- R8: If no acknowledge arrives, AS is low for exactly TIMEOUT_CYC cycles. The cycle then ends with the error flag set and the result data zero.
- R9: Done is high for exactly one clock. At that point AS is high, DS is 11 and LWORD is high.
- R10: A 16-bit request with address bit 0 set, a 32-bit request with either of address bits 1:0 set, or size code 11 completes on the next cycle with the error flag set. AS is never asserted for it.
- R11: A request presented while a cycle is in progress is ignored. It does not change the address lines and starts no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled when idle |
| req_addr_i | input | 32 | Byte address |
| req_am_i | input | 6 | Address modifier |
| req_size_i | input | 2 | 00 byte, 01 16-bit, 10 32-bit, 11 invalid |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Timeout or misaligned request |
| rsp_data_o | output | 32 | Read data, right-aligned |
| vme_addr_o | output | 31 | Address lines 31:1 |
| vme_am_o | output | 6 | Address modifier lines |
| vme_iack_n_o | output | 1 | Interrupt acknowledge, held high |
| vme_lword_n_o | output | 1 | Long-word select, active low |
| vme_write_n_o | output | 1 | Write select, held high (read) |
| vme_as_n_o | output | 1 | Address strobe, active low |
| vme_ds_n_o | output | 2 | Data strobes, active low |
| vme_dtack_n_i | input | 1 | Slave acknowledge, active low |
| vme_dtack_oe_i | input | 1 | Slave acknowledge drive enable |
| vme_berr_i | input | 1 | Bus error indication |
| vme_data_i | input | 32 | Data bus |

## Verification
The hardest case to reach is a bus that is still busy from an earlier slave when AS falls. The bench forces the acknowledge drive enable, or BERR, high before issuing a request. It keeps it high for several cycles after AS has dropped and records any strobe seen during that window. The release then takes effect only after the synchronizer delay. The bench also sends a second request in the middle of a cycle and watches both the address lines and done over the following cycles.

// File: rtl/vme_rd_pkg.sv
package vme_rd_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_X = 2'b11
  } rd_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WCLR,
    ST_STRB,
    ST_FIN
  } rd_state_e;
endpackage

// File: rtl/vme_rd_sync.sv
module vme_rd_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vme_rd_cnt.sv
module vme_rd_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/vme_rd_lane.sv
module vme_rd_lane
  import vme_rd_pkg::*;
(
  input  rd_size_e   size_i,
  input  logic [1:0] ofs_i,
  output logic [1:0] ds_n_o,
  output logic       lword_n_o,
  output logic       bad_o
);
  always_comb begin
    ds_n_o    = 2'b11;
    lword_n_o = 1'b1;
    bad_o     = 1'b0;
    unique case (size_i)
      SZ_B: ds_n_o = ofs_i[0] ? 2'b10 : 2'b01;
      SZ_H: begin
        ds_n_o = 2'b00;
        bad_o  = ofs_i[0];
      end
      SZ_W: begin
        ds_n_o    = 2'b00;
        lword_n_o = 1'b0;
        bad_o     = |ofs_i;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vme_rd_extract.sv
module vme_rd_extract
  import vme_rd_pkg::*;
#(
  parameter int DW = 32
) (
  input  rd_size_e        size_i,
  input  logic            a0_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    unique case (size_i)
      SZ_B:    data_o[7:0]  = a0_i ? data_i[7:0] : data_i[15:8];
      SZ_H:    data_o[15:0] = data_i[15:0];
      SZ_W:    data_o       = data_i;
      default: data_o       = '0;
    endcase
  end
endmodule

// File: rtl/vme_rd_master.sv
module vme_rd_master
  import vme_rd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int AMW         = 6,
  parameter int SETUP_CYC   = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [AMW-1:0] req_am_i,
  input  logic [1:0]     req_size_i,
  output logic           rsp_done_o,
  output logic           rsp_err_o,
  output logic [DW-1:0]  rsp_data_o,
  output logic [AW-2:0]  vme_addr_o,
  output logic [AMW-1:0] vme_am_o,
  output logic           vme_iack_n_o,
  output logic           vme_lword_n_o,
  output logic           vme_write_n_o,
  output logic           vme_as_n_o,
  output logic [1:0]     vme_ds_n_o,
  input  logic           vme_dtack_n_i,
  input  logic           vme_dtack_oe_i,
  input  logic           vme_berr_i,
  input  logic [DW-1:0]  vme_data_i
);
  localparam int MAXC = (SETUP_CYC > TIMEOUT_CYC) ? SETUP_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int SW   = DW + 3;

  rd_state_e      state_q;
  logic [AW-2:0]  addr_q;
  logic [AMW-1:0] am_q;
  logic           lword_q, as_n_q, a0_q, err_q;
  logic [1:0]     ds_n_q, ds_sel_q;
  rd_size_e       size_q;
  logic [DW-1:0]  data_q;

  logic [DW-1:0]  data_s, ext_data;
  logic           dtack_n_s, oe_s, berr_s;
  logic [1:0]     req_ds_n;
  logic           req_lword_n, req_bad;
  logic [CW-1:0]  cnt;
  logic           cnt_clr, setup_end, to_end, ack;

  vme_rd_sync #(.W(SW), .RST_VAL({1'b1, {(SW-1){1'b0}}})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vme_dtack_n_i, vme_dtack_oe_i, vme_berr_i, vme_data_i}),
    .q_o   ({dtack_n_s, oe_s, berr_s, data_s})
  );

  vme_rd_lane u_lane (
    .size_i   (rd_size_e'(req_size_i)),
    .ofs_i    (req_addr_i[1:0]),
    .ds_n_o   (req_ds_n),
    .lword_n_o(req_lword_n),
    .bad_o    (req_bad)
  );

  vme_rd_extract #(.DW(DW)) u_ext (
    .size_i(size_q),
    .a0_i  (a0_q),
    .data_i(data_s),
    .data_o(ext_data)
  );

  vme_rd_cnt #(.W(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .q_o   (cnt)
  );

  assign setup_end = (cnt == CW'(SETUP_CYC - 1));
  assign to_end    = (cnt == CW'(TIMEOUT_CYC - 1));
  assign ack       = oe_s & ~dtack_n_s;
  assign cnt_clr   = (state_q == ST_IDLE) || ((state_q == ST_SETUP) && setup_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      am_q     <= '0;
      lword_q  <= 1'b1;
      as_n_q   <= 1'b1;
      ds_n_q   <= 2'b11;
      ds_sel_q <= 2'b11;
      size_q   <= SZ_B;
      a0_q     <= 1'b0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (req_bad) begin
            err_q   <= 1'b1;
            data_q  <= '0;
            state_q <= ST_FIN;
          end else begin
            addr_q   <= req_addr_i[AW-1:1];
            am_q     <= req_am_i;
            lword_q  <= req_lword_n;
            ds_sel_q <= req_ds_n;
            size_q   <= rd_size_e'(req_size_i);
            a0_q     <= req_addr_i[0];
            state_q  <= ST_SETUP;
          end
        end
        ST_SETUP: if (setup_end) begin
          as_n_q  <= 1'b0;
          state_q <= ST_WCLR;
        end
        ST_WCLR: begin
          if (to_end) begin
            as_n_q  <= 1'b1;
            lword_q <= 1'b1;
            err_q   <= 1'b1;
            data_q  <= '0;
            state_q <= ST_FIN;
          end else if (!oe_s && !berr_s) begin
            ds_n_q  <= ds_sel_q;
            state_q <= ST_STRB;
          end
        end
        ST_STRB: begin
          if (ack || to_end) begin
            as_n_q  <= 1'b1;
            ds_n_q  <= 2'b11;
            lword_q <= 1'b1;
            err_q   <= ~ack;
            data_q  <= ack ? ext_data : '0;
            state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_done_o    = (state_q == ST_FIN);
  assign rsp_err_o     = err_q;
  assign rsp_data_o    = data_q;
  assign vme_addr_o    = addr_q;
  assign vme_am_o      = am_q;
  assign vme_iack_n_o  = 1'b1;
  assign vme_write_n_o = 1'b1;
  assign vme_lword_n_o = lword_q;
  assign vme_as_n_o    = as_n_q;
  assign vme_ds_n_o    = ds_n_q;
endmodule

// File: rtl/vme_rd_master_chk.sv
module vme_rd_master_chk #(
  parameter int AW          = 32,
  parameter int AMW         = 6,
  parameter int TIMEOUT_CYC = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           as_n,
  input logic [1:0]     ds_n,
  input logic           lword_n,
  input logic [AW-2:0]  addr,
  input logic [AMW-1:0] am,
  input logic           done,
  input logic           oe_s,
  input logic           berr_s
);
  logic [31:0] as_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   as_cnt <= '0;
    else if (as_n) as_cnt <= '0;
    else           as_cnt <= as_cnt + 1;
  end

  a_r2_addr_stable_at_as: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_n) |-> ($stable(addr) && $stable(am)));

  a_r3_no_strobe_before_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_n != 2'b11 && $past(ds_n) == 2'b11) |-> $past(!oe_s && !berr_s));

  a_r3_strobe_inside_as: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_n != 2'b11) |-> !as_n);

  a_r8_as_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_cnt <= 32'(TIMEOUT_CYC));

  a_r9_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (as_n && ds_n == 2'b11 && lword_n));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);
endmodule

bind vme_rd_master vme_rd_master_chk #(.AW(AW), .AMW(AMW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .as_n   (vme_as_n_o),
  .ds_n   (vme_ds_n_o),
  .lword_n(vme_lword_n_o),
  .addr   (vme_addr_o),
  .am     (vme_am_o),
  .done   (rsp_done_o),
  .oe_s   (oe_s),
  .berr_s (berr_s)
);

// File: tb/sim_vme_rd_master.sv
module sim_vme_rd_master;
  localparam int SETUP = 4;
  localparam int TMO   = 40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_am = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_data;
  logic [30:0] vme_addr;
  logic [5:0]  vme_am;
  logic        iack_n, lword_n, write_n, as_n;
  logic [1:0]  ds_n;
  logic        dtack_n, dtack_oe, berr;
  logic [31:0] vdata;

  logic        slave_en = 1'b1, stale_oe = 1'b0, stale_berr = 1'b0;
  logic        resp_oe = 1'b0, resp_dtack_n = 1'b1;
  int          lat_cnt = 0;
  localparam logic [31:0] MEM = 32'hA1B2C3D4;

  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  assign dtack_oe = stale_oe | resp_oe;
  assign dtack_n  = resp_dtack_n;
  assign berr     = stale_berr;
  assign vdata    = resp_oe ? MEM : 32'h0;

  vme_rd_master #(.SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_am_i(req_am), .req_size_i(req_size),
    .rsp_done_o(rsp_done), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data),
    .vme_addr_o(vme_addr), .vme_am_o(vme_am), .vme_iack_n_o(iack_n),
    .vme_lword_n_o(lword_n), .vme_write_n_o(write_n), .vme_as_n_o(as_n), .vme_ds_n_o(ds_n),
    .vme_dtack_n_i(dtack_n), .vme_dtack_oe_i(dtack_oe), .vme_berr_i(berr), .vme_data_i(vdata)
  );

  // slave model, acts on the falling edge
  always @(negedge clk) begin
    if (slave_en && ds_n != 2'b11 && !as_n) begin
      if (lat_cnt >= 2) begin
        resp_oe      <= 1'b1;
        resp_dtack_n <= 1'b0;
      end else lat_cnt <= lat_cnt + 1;
    end else begin
      resp_oe      <= 1'b0;
      resp_dtack_n <= 1'b1;
      lat_cnt      <= 0;
    end
  end

  // per-read observations
  bit          r_done, r_err, r_rel, r_single, r_early, r_ds_seen;
  logic [31:0] r_data;
  logic [1:0]  r_ds;
  logic        r_lword;
  logic [30:0] r_addr;
  logic [5:0]  r_am;
  int          r_setup, r_aslow;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [5:0] am, input logic [1:0] sz);
    bit seen_low = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_am = am; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    r_done = 0; r_err = 0; r_rel = 0; r_single = 0; r_early = 0; r_ds_seen = 0;
    r_data = '0; r_ds = 2'b11; r_lword = 1'b1; r_addr = '0; r_am = '0;
    r_setup = 0; r_aslow = 0;
    for (int i = 0; i < 1000; i++) begin
      if (as_n && !seen_low) r_setup++;
      if (!as_n) begin
        if (!seen_low) begin r_addr = vme_addr; r_am = vme_am; end
        seen_low = 1;
        r_aslow++;
      end
      if (ds_n != 2'b11 && !r_ds_seen) begin r_ds = ds_n; r_lword = lword_n; r_ds_seen = 1; end
      if (ds_n != 2'b11 && (stale_oe || stale_berr)) r_early = 1;
      if (rsp_done) begin
        r_done = 1; r_err = rsp_err; r_data = rsp_data;
        r_rel = as_n && ds_n == 2'b11 && lword_n;
        @(negedge clk);
        r_single = !rsp_done;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(as_n == 1'b1 && ds_n == 2'b11, "R9 reset strobes", {29'b0, as_n, ds_n}, 32'h7);
    chk(!rsp_done && lword_n, "R9 reset done/lword", {30'b0, rsp_done, lword_n}, 32'h1);
    chk(iack_n && write_n, "R1 reset iack/write", {30'b0, iack_n, write_n}, 32'h3);
  endtask

  task automatic t_byte(input logic [31:0] a, input logic [1:0] eds, input logic [7:0] ed);
    do_read(a, 6'h09, 2'b00);
    chk(r_done && !r_err, "R7 byte ack no error", {31'b0, r_err}, 32'h0);
    chk(r_ds == eds && r_lword, "R4 byte strobes/lword", {29'b0, r_lword, r_ds}, {29'b0, 1'b1, eds});
    chk(r_data == {24'h0, ed}, "R4 byte data", r_data, {24'h0, ed});
    chk(r_addr == a[31:1] && r_am == 6'h09, "R1 byte address/am", {1'b0, r_addr}, {1'b0, a[31:1]});
    chk(r_setup == SETUP, "R2 setup cycles", r_setup, SETUP);
    chk(r_rel && r_single, "R9 release and single done", {30'b0, r_rel, r_single}, 32'h3);
  endtask

  task automatic t_half;
    do_read(32'h5600_0012, 6'h0D, 2'b01);
    chk(r_done && !r_err, "R7 half ack", {31'b0, r_err}, 32'h0);
    chk(r_ds == 2'b00 && r_lword, "R5 half strobes/lword", {29'b0, r_lword, r_ds}, 32'h4);
    chk(r_data == 32'h0000C3D4, "R5 half data", r_data, 32'h0000C3D4);
  endtask

  task automatic t_word;
    do_read(32'h5600_0014, 6'h0D, 2'b10);
    chk(r_done && !r_err, "R7 word ack", {31'b0, r_err}, 32'h0);
    chk(r_ds == 2'b00 && !r_lword, "R6 word strobes/lword", {29'b0, r_lword, r_ds}, 32'h0);
    chk(r_data == MEM, "R6 word data", r_data, MEM);
    chk(r_am == 6'h0D && write_n && iack_n, "R1 word am/write/iack", {26'b0, r_am}, 32'h0D);
  endtask

  task automatic t_misalign(input logic [31:0] a, input logic [1:0] sz, input string tag);
    do_read(a, 6'h09, sz);
    chk(r_done && r_err, {"R10 error flag ", tag}, {30'b0, r_done, r_err}, 32'h3);
    chk(r_aslow == 0, {"R10 no bus cycle ", tag}, r_aslow, 0);
  endtask

  task automatic t_timeout;
    slave_en = 1'b0;
    do_read(32'h0000_0100, 6'h09, 2'b10);
    slave_en = 1'b1;
    chk(r_done && r_err, "R8 timeout error", {30'b0, r_done, r_err}, 32'h3);
    chk(r_aslow == TMO, "R8 AS low window", r_aslow, TMO);
    chk(r_data == 32'h0, "R8 data zero", r_data, 32'h0);
    chk(r_rel, "R9 release after timeout", {31'b0, r_rel}, 32'h1);
  endtask

  task automatic t_stale(input bit use_berr);
    if (use_berr) stale_berr = 1'b1; else stale_oe = 1'b1;
    repeat (4) @(negedge clk);
    fork
      do_read(32'h0000_0020, 6'h09, 2'b01);
      begin
        wait (!as_n);
        repeat (8) @(negedge clk);
        stale_oe = 1'b0;
        stale_berr = 1'b0;
      end
    join
    chk(!r_early, use_berr ? "R3 no strobe while berr" : "R3 no strobe while oe", {31'b0, r_early}, 32'h0);
    chk(r_done && !r_err && r_data == 32'h0000C3D4, "R3 completes after clear", r_data, 32'h0000C3D4);
  endtask

  task automatic t_ignore;
    bit extra = 0;
    fork
      do_read(32'h0000_0040, 6'h09, 2'b10);
      begin
        wait (!as_n);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0888; req_size = 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    chk(r_addr == 31'h20 && vme_addr == 31'h20, "R11 address unchanged", {1'b0, vme_addr}, 32'h20);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rsp_done || !as_n) extra = 1;
    end
    chk(!extra, "R11 no second cycle", {31'b0, extra}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_byte(32'h5600_0010, 2'b01, 8'hC3);
    t_byte(32'h5600_0011, 2'b10, 8'hD4);
    t_half();
    t_word();
    t_misalign(32'h0000_0013, 2'b01, "half odd");
    t_misalign(32'h0000_0016, 2'b10, "word bit1");
    t_misalign(32'h0000_0000, 2'b11, "size 11");
    t_timeout();
    t_stale(1'b0);
    t_stale(1'b1);
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule